// File: doc/BRIEF.md
# External Interrupt Edge-Flag Controller

This block monitors twelve asynchronous external interrupt pins. Each pin has its own polarity bit, which selects whether a rising or a falling transition counts as an event. An event latches a sticky flag for that pin. The flag stays set until software writes it to zero or the block is reset. The block drives one interrupt request line to the CPU. That line is high whenever at least one flag is set while its matching enable bit is also set.

Software reaches the block through a byte-wide special-function-register port with separate read and write strobes, a module select and a register index. Three registers are decoded under module 01h:

- Index 04h holds flags 7:0.
- Index 05h holds the enables for sources 7:0.
- Index 06h holds flags 11:8 in bits 3:0.

A neighbouring register block supplies the polarity bits and the enables for sources 11:8 as plain input ports. Every pin passes through a two-flop synchronizer before edge detection. Edge detection stays off until the synchronizer pipeline holds real samples after reset.

Top module: `extint_edge_ctrl`

## Requirements
- R1: With polarity bit 0, a rising transition on a pin sets that pin's flag about three clock edges later. A falling transition on that pin leaves the flag unchanged.
- R2: With polarity bit 1, a falling transition on a pin sets that pin's flag. A rising transition on that pin leaves the flag unchanged.
- R3: A flag stays set until it is written 0 or the block is reset. A pin held at a steady level after its flag was cleared does not set the flag again.
- R4: `irq_o` is 1 whenever any flag is 1 while its enable is 1. It stays 1 for as long as such a pair remains set.
- R5: An enable of 0 keeps its source out of `irq_o` and does not change the flag. Enables 7:0 are bits 7:0 of index 05h. Enables 11:8 come from `en_hi_i[3:0]`.
- R6: Reset clears all flags and the low enables. A pin that is already at its active level while reset is released does not set a flag.
- R7: Index 06h bits 3:0 read and write flags 11:8. Bits 7:4 always read 0, and writes to them are ignored.
- R8: Writing 1 to a flag bit sets that flag, which gives a software-triggered interrupt.
- R9: If a hardware edge sets a flag in the same cycle that software writes 0 to it, the flag ends up 1. Other bits in that write still take the written value.
- R10: Registers respond only when `sfr_mod_i` equals 1. Index 04h bits 7:0 map to flags 7:0. `sfr_rdata_o` is 0 when no read hits a register, and writes to any other module leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 12 | Asynchronous interrupt pins |
| pol_i | input | 12 | Per-pin polarity: 1 = falling edge, 0 = rising edge |
| en_hi_i | input | 4 | Enables for sources 11:8 |
| sfr_mod_i | input | 4 | Register module select |
| sfr_idx_i | input | 5 | Register index within the module |
| sfr_wr_i | input | 1 | Write strobe |
| sfr_rd_i | input | 1 | Read strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Combinational read data |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench drives a software clear in the same cycle that an edge arrives. A design that let the write win would lose that interrupt. It clears a flag while the pin stays at its active level, which catches a level-triggered design because the flag would come straight back. It releases reset with every pin already high and polarity set to rising, which exposes a design that treats the synchronizer's reset value as a real edge. It also writes all ones to the upper flag register and checks that the reserved bits read zero, and it writes 0 to an enable to confirm that masking hides the request without clearing the flag.

// File: rtl/extint_pkg.sv
package extint_pkg;
   // register selected by a decoded access
   typedef enum logic [1:0] {
      SEL_NONE    = 2'd0,
      SEL_FLAG_LO = 2'd1,
      SEL_EN_LO   = 2'd2,
      SEL_FLAG_HI = 2'd3
   } reg_sel_e;

   localparam int unsigned SFR_DW = 8;

   function automatic reg_sel_e decode_sel(
      input logic hit, input logic [7:0] idx,
      input logic [7:0] i_flo, input logic [7:0] i_elo, input logic [7:0] i_fhi);
      reg_sel_e s;
      s = SEL_NONE;
      if (hit) begin
         if (idx == i_flo)      s = SEL_FLAG_LO;
         else if (idx == i_elo) s = SEL_EN_LO;
         else if (idx == i_fhi) s = SEL_FLAG_HI;
      end
      return s;
   endfunction
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det #(
   parameter int unsigned WIDTH       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_i,
   input  logic [WIDTH-1:0] pol_i,
   output logic [WIDTH-1:0] edge_o
);
   // edges are only trusted once the previous-sample register holds a real pin value
   localparam int unsigned FILL  = SYNC_STAGES + 1;
   localparam int unsigned CNT_W = $clog2(FILL + 1);
   localparam logic [CNT_W-1:0] FILL_C = CNT_W'(FILL);

   logic [WIDTH-1:0] prev_q;
   logic [CNT_W-1:0] fill_q;
   logic             primed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         fill_q <= '0;
      end else begin
         prev_q <= sync_i;
         if (fill_q != FILL_C) fill_q <= fill_q + 1'b1;
      end
   end

   assign primed = (fill_q == FILL_C);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic rise, fall;
      assign rise      = sync_i[i] & ~prev_q[i];
      assign fall      = ~sync_i[i] & prev_q[i];
      assign edge_o[i] = primed & (pol_i[i] ? fall : rise);
   end
endmodule

// File: rtl/extint_flag_bank.sv
module extint_flag_bank #(
   parameter int unsigned NUM_SRC = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_set_i,
   input  logic               wr_lo_i,
   input  logic               wr_hi_i,
   input  logic [7:0]         wdata_i,
   output logic [NUM_SRC-1:0] flags_o
);
   logic [NUM_SRC-1:0] flag_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      logic wr_en, wr_val;
      if (i < 8) begin : g_lo
         assign wr_en  = wr_lo_i;
         assign wr_val = wdata_i[i];
      end else begin : g_hi
         assign wr_en  = wr_hi_i;
         assign wr_val = wdata_i[i-8];
      end

      // a hardware edge overrides any software value in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           flag_q[i] <= 1'b0;
         else if (hw_set_i[i]) flag_q[i] <= 1'b1;
         else if (wr_en)       flag_q[i] <= wr_val;
      end
   end

   assign flags_o = flag_q;
endmodule

// File: rtl/extint_edge_ctrl.sv
module extint_edge_ctrl #(
   parameter int unsigned NUM_SRC     = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MOD_W       = 4,
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned MOD_ID      = 1,
   parameter int unsigned IDX_FLAG_LO = 4,
   parameter int unsigned IDX_EN_LO   = 5,
   parameter int unsigned IDX_FLAG_HI = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pin_i,
   input  logic [NUM_SRC-1:0] pol_i,
   input  logic [NUM_SRC-9:0] en_hi_i,
   input  logic [MOD_W-1:0]   sfr_mod_i,
   input  logic [IDX_W-1:0]   sfr_idx_i,
   input  logic               sfr_wr_i,
   input  logic               sfr_rd_i,
   input  logic [7:0]         sfr_wdata_i,
   output logic [7:0]         sfr_rdata_o,
   output logic               irq_o
);
   import extint_pkg::*;

   localparam int unsigned HI_N = NUM_SRC - 8;

   if (NUM_SRC < 9 || NUM_SRC > 16) begin : g_bad_src
      $error("extint_edge_ctrl: NUM_SRC must lie in 9..16");
   end
   if (IDX_FLAG_LO == IDX_EN_LO || IDX_FLAG_LO == IDX_FLAG_HI || IDX_EN_LO == IDX_FLAG_HI) begin : g_bad_idx
      $error("extint_edge_ctrl: register indices must differ");
   end
   if (MOD_W > 8 || IDX_W > 8) begin : g_bad_addr
      $error("extint_edge_ctrl: address fields wider than a byte");
   end

   logic [NUM_SRC-1:0] pin_sync, edge_hit, flag_q, en_all;
   logic [7:0]         en_lo_q, hi_byte;
   logic               mod_hit;
   reg_sel_e           wsel, rsel;

   extint_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync));

   extint_edge_det #(.WIDTH(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .sync_i(pin_sync), .pol_i(pol_i), .edge_o(edge_hit));

   assign mod_hit = (sfr_mod_i == MOD_W'(MOD_ID));

   always_comb begin
      wsel = decode_sel(mod_hit & sfr_wr_i, 8'(sfr_idx_i),
                        8'(IDX_FLAG_LO), 8'(IDX_EN_LO), 8'(IDX_FLAG_HI));
      rsel = decode_sel(mod_hit & sfr_rd_i, 8'(sfr_idx_i),
                        8'(IDX_FLAG_LO), 8'(IDX_EN_LO), 8'(IDX_FLAG_HI));
   end

   extint_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .hw_set_i(edge_hit),
      .wr_lo_i(wsel == SEL_FLAG_LO), .wr_hi_i(wsel == SEL_FLAG_HI),
      .wdata_i(sfr_wdata_i), .flags_o(flag_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 en_lo_q <= '0;
      else if (wsel == SEL_EN_LO) en_lo_q <= sfr_wdata_i;
   end

   assign en_all = {en_hi_i, en_lo_q};
   assign irq_o  = |(flag_q & en_all);

   always_comb begin
      hi_byte = '0;
      hi_byte[HI_N-1:0] = flag_q[NUM_SRC-1:8];
   end

   always_comb begin
      unique case (rsel)
         SEL_FLAG_LO: sfr_rdata_o = flag_q[7:0];
         SEL_EN_LO:   sfr_rdata_o = en_lo_q;
         SEL_FLAG_HI: sfr_rdata_o = hi_byte;
         default:     sfr_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/extint_edge_ctrl_chk.sv
module extint_edge_ctrl_chk #(
   parameter int unsigned NUM_SRC     = 12,
   parameter int unsigned MOD_W       = 4,
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned MOD_ID      = 1,
   parameter int unsigned IDX_FLAG_LO = 4,
   parameter int unsigned IDX_EN_LO   = 5,
   parameter int unsigned IDX_FLAG_HI = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [MOD_W-1:0]   sfr_mod_i,
   input logic [IDX_W-1:0]   sfr_idx_i,
   input logic               sfr_wr_i,
   input logic               sfr_rd_i,
   input logic [7:0]         sfr_rdata_o,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] flags,
   input logic [7:0]         en_lo
);
   logic hit, wr_flag, wr_en, rd_hi;
   assign hit     = (sfr_mod_i == MOD_W'(MOD_ID));
   assign wr_flag = sfr_wr_i && hit &&
                    (sfr_idx_i == IDX_W'(IDX_FLAG_LO) || sfr_idx_i == IDX_W'(IDX_FLAG_HI));
   assign wr_en   = sfr_wr_i && hit && (sfr_idx_i == IDX_W'(IDX_EN_LO));
   assign rd_hi   = sfr_rd_i && hit && (sfr_idx_i == IDX_W'(IDX_FLAG_HI));

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> (($past(flags) & ~flags) == '0)); // R3

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flags != '0)); // R4

   AST_MASK_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_flag) |=> (($past(flags) & ~flags) == '0)); // R5

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (flags == '0 && en_lo == '0)); // R6

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |-> (sfr_rdata_o[7:4] == 4'h0)); // R7

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!sfr_rd_i || !hit) |-> (sfr_rdata_o == 8'h00)); // R10
endmodule

bind extint_edge_ctrl extint_edge_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .MOD_W(MOD_W), .IDX_W(IDX_W), .MOD_ID(MOD_ID),
   .IDX_FLAG_LO(IDX_FLAG_LO), .IDX_EN_LO(IDX_EN_LO), .IDX_FLAG_HI(IDX_FLAG_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sfr_mod_i(sfr_mod_i), .sfr_idx_i(sfr_idx_i),
   .sfr_wr_i(sfr_wr_i), .sfr_rd_i(sfr_rd_i), .sfr_rdata_o(sfr_rdata_o),
   .irq_o(irq_o), .flags(flag_q), .en_lo(en_lo_q)
);

// File: tb/extint_edge_ctrl_tb.sv
module extint_edge_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] pin_i = 12'hFFF;
   logic [11:0] pol_i = 12'h000;
   logic [3:0]  en_hi_i = 4'h0;
   logic [3:0]  sfr_mod_i = 4'h0;
   logic [4:0]  sfr_idx_i = 5'h0;
   logic        sfr_wr_i = 1'b0;
   logic        sfr_rd_i = 1'b0;
   logic [7:0]  sfr_wdata_i = 8'h00;
   logic [7:0]  sfr_rdata_o;
   logic        irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   extint_edge_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pol_i(pol_i), .en_hi_i(en_hi_i),
      .sfr_mod_i(sfr_mod_i), .sfr_idx_i(sfr_idx_i), .sfr_wr_i(sfr_wr_i),
      .sfr_rd_i(sfr_rd_i), .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o),
      .irq_o(irq_o));

   // {polarity, pins before, pins after, expected flags}
   localparam logic [47:0] VEC [7] = '{
      {12'h000, 12'h000, 12'hFFF, 12'hFFF},   // R1 all rising
      {12'hFFF, 12'hFFF, 12'h000, 12'hFFF},   // R2 all falling
      {12'h000, 12'hFFF, 12'h000, 12'h000},   // R1 falling ignored
      {12'hF0F, 12'h000, 12'hFFF, 12'h0F0},   // R2 rising ignored where pol=1
      {12'hF0F, 12'hFFF, 12'h000, 12'hF0F},   // R2 mixed falling
      {12'h000, 12'h555, 12'hAAA, 12'hAAA},   // R1 alternating
      {12'hFFF, 12'h555, 12'hAAA, 12'h555}    // R2 alternating
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic sfr_write(input logic [3:0] m, input logic [4:0] idx, input logic [7:0] d);
      @(negedge clk);
      sfr_mod_i = m; sfr_idx_i = idx; sfr_wdata_i = d; sfr_wr_i = 1'b1;
      @(negedge clk);
      sfr_wr_i = 1'b0;
   endtask

   task automatic sfr_read(input logic [3:0] m, input logic [4:0] idx, output logic [7:0] d);
      @(negedge clk);
      sfr_mod_i = m; sfr_idx_i = idx; sfr_rd_i = 1'b1;
      #1 d = sfr_rdata_o;
      sfr_rd_i = 1'b0;
   endtask

   task automatic read_flags(output logic [11:0] f);
      logic [7:0] lo, hi;
      sfr_read(4'h1, 5'h04, lo);
      sfr_read(4'h1, 5'h06, hi);
      f = {hi[3:0], lo};
   endtask

   task automatic clear_flags();
      sfr_write(4'h1, 5'h04, 8'h00);
      sfr_write(4'h1, 5'h06, 8'h00);
   endtask

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [11:0] f;
      logic [7:0]  d;

      // R6: pins already high with rising polarity through reset release
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(8);
      read_flags(f);
      check("R6 no flag from level at reset", 32'(f), 32'h000);
      sfr_read(4'h1, 5'h05, d);
      check("R6 enable reset", 32'(d), 32'h00);
      check("R6 irq reset", 32'(irq_o), 32'h0);

      // vector table: R1 / R2
      for (int i = 0; i < 7; i++) begin
         pol_i = VEC[i][47:36];
         pin_i = VEC[i][35:24];
         wait_clk(5);
         clear_flags();
         pin_i = VEC[i][23:12];
         wait_clk(5);
         read_flags(f);
         check($sformatf("R1/R2 vector %0d", i), 32'(f), 32'(VEC[i][11:0]));
      end

      // R3: pins still at active level, flags cleared, must stay clear
      pol_i = 12'h000; pin_i = 12'h000;
      wait_clk(5);
      clear_flags();
      pin_i = 12'h001;
      wait_clk(5);
      pin_i = 12'h000;
      wait_clk(5);
      read_flags(f);
      check("R3 sticky after pin returns", 32'(f), 32'h001);
      pin_i = 12'h001;
      wait_clk(5);
      clear_flags();
      wait_clk(6);
      read_flags(f);
      check("R3 held level does not re-set", 32'(f), 32'h000);
      pin_i = 12'h000;
      wait_clk(5);

      // R8: software set
      sfr_write(4'h1, 5'h06, 8'h04);
      read_flags(f);
      check("R8 software set flag 10", 32'(f), 32'h400);

      // R4 / R5: masking
      check("R5 masked irq low", 32'(irq_o), 32'h0);
      en_hi_i = 4'h4;
      #1 check("R4 irq with enable 10", 32'(irq_o), 32'h1);
      wait_clk(4);
      check("R4 irq held while flag set", 32'(irq_o), 32'h1);
      en_hi_i = 4'h0;
      wait_clk(2);
      read_flags(f);
      check("R5 mask keeps flag", 32'(f), 32'h400);
      check("R5 masked irq", 32'(irq_o), 32'h0);
      sfr_write(4'h1, 5'h04, 8'h80);
      sfr_write(4'h1, 5'h05, 8'h80);
      check("R4 irq low enable 7", 32'(irq_o), 32'h1);
      sfr_write(4'h1, 5'h04, 8'h00);
      check("R3 cleared by write 0 irq drops", 32'(irq_o), 32'h0);
      sfr_write(4'h1, 5'h05, 8'h00);

      // R7: reserved bits
      sfr_write(4'h1, 5'h06, 8'hFF);
      sfr_read(4'h1, 5'h06, d);
      check("R7 upper reg reserved bits zero", 32'(d), 32'h0F);
      clear_flags();
      read_flags(f);
      check("R7 upper flags cleared", 32'(f), 32'h000);

      // R10: foreign module write / read ignored
      sfr_write(4'h3, 5'h04, 8'hFF);
      read_flags(f);
      check("R10 other module write ignored", 32'(f), 32'h000);
      sfr_write(4'h1, 5'h04, 8'h5A);
      sfr_read(4'h2, 5'h04, d);
      check("R10 other module reads zero", 32'(d), 32'h00);
      sfr_read(4'h1, 5'h07, d);
      check("R10 unmapped index reads zero", 32'(d), 32'h00);
      sfr_read(4'h1, 5'h04, d);
      check("R10 low flag byte", 32'(d), 32'h5A);

      // R9: hardware set collides with software clear
      sfr_write(4'h1, 5'h04, 8'h01);
      @(negedge clk);
      pin_i = 12'h008;               // seen at next posedge (k)
      @(posedge clk);                // k
      @(posedge clk);                // k+1
      @(negedge clk);
      sfr_mod_i = 4'h1; sfr_idx_i = 5'h04; sfr_wdata_i = 8'h00; sfr_wr_i = 1'b1;
      @(negedge clk);                // posedge k+2 in between
      sfr_wr_i = 1'b0;
      sfr_read(4'h1, 5'h04, d);
      check("R9 hardware set beats write 0", 32'(d), 32'h08);

      // R6: reset in mid-run clears flags and enables
      sfr_write(4'h1, 5'h05, 8'hFF);
      @(negedge clk) rst_n = 1'b0;
      wait_clk(2);
      rst_n = 1'b1;
      sfr_read(4'h1, 5'h05, d);
      check("R6 enables cleared by reset", 32'(d), 32'h00);
      read_flags(f);
      check("R6 flags cleared by reset", 32'(f), 32'h000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule